// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two 8-bit signed two's-complement numbers and returns the full 16-bit signed product. Signed handling is folded into the partial products: a partial-product bit is inverted when exactly one of its two operand bits is a sign bit, and two constant ones are added to the sum. No negation or sign-fix pass runs before or after the array.

The partial products are summed by a regular chain of full-adder rows in carry-save form, one row per multiplier bit, rather than by a tree. A register follows every row. The final carry-propagate addition is split into registered 2-bit slices. Operand bits ride along in skew registers beside the partial sums, so each row works on the operands of its own multiplication.

The unit accepts a new operand pair on every clock. A valid flag travels with each operation and marks the cycle in which its product appears.

Top module: `bw_mult`

## Requirements
- R1: While `out_vld` is high, `product` equals the two's-complement product of the signed operand pair it belongs to, as a 16-bit signed value.
- R2: Operands presented with `in_vld` high in clock cycle n produce `out_vld` high with their product in cycle n+17, counting cycles by rising clock edges.
- R3: Operand pairs may arrive on every consecutive cycle. Each pair yields its own product, and the products come out in the same order as the pairs went in, one per cycle.
- R4: A cycle with `in_vld` low produces a cycle with `out_vld` low 17 cycles later, whatever the operand inputs held.
- R5: `rst_n` is a synchronous, active-low reset. In the cycle after a reset edge `out_vld` is low, and operations in flight at the reset never raise `out_vld`.
- R6: The extreme operand values give exact results: -128 × -128 = 16384 (0x4000), -128 × 127 = -16256 (0xC080), x × 0 = 0 and x × -1 = -x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears the valid flags |
| in_vld | input | 1 | Marks the operands on `op_a` and `op_b` as a request |
| op_a | input | 8 | Multiplicand, signed two's complement |
| op_b | input | 8 | Multiplier, signed two's complement |
| out_vld | output | 1 | High in the cycle a product is presented |
| product | output | 16 | Signed two's-complement product |

## Verification
The hardest case to reach is a long unbroken run of accepted operands. In that run every row register and every carry-propagate slice holds a different operation, so any skew error between the carried operand bits and the partial sums would mix two multiplications together. The bench streams corner and random pairs back to back with no gaps. It then runs a stream with scattered `in_vld` bubbles and junk operands in the idle cycles. A reset is also applied while the pipeline is full, to show that operations in flight are dropped.

// File: rtl/bw_mult_pkg.sv
// Package: shared constants and helpers for the signed array multiplier.
// Assumes operand width of at least 2 and a product width of twice that.
package bw_mult_pkg;

    localparam int OP_W_DEF       = 8;
    localparam int CPA_STAGES_DEF = 8;

    // Constant injected at the start of the array: ones at bit OP_W and at
    // bit 2*OP_W-1, which cancel the offset of the inverted sign-row terms.
    function automatic logic [2*OP_W_DEF-1:0] corr_const(input int op_w);
        logic [2*OP_W_DEF-1:0] v;
        v = '0;
        v[op_w]         = 1'b1;
        v[2*op_w - 1]   = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bw_row_stage.sv
// Module: one full-adder row of the carry-save array plus its register.
// Forms the partial-product row for multiplier bit ROW. Terms that pair a
// sign bit with a non-sign bit are inverted, and the sign-by-sign term
// stays plain. The row is added to the incoming sum and carry vectors.
// Assumes ROW < OP_W. Data registers carry no reset.
module bw_row_stage #(
    parameter int OP_W = 8,
    parameter int ROW  = 0,
    localparam int P_W = 2 * OP_W
) (
    input  logic            clk,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    input  logic [P_W-1:0]  s_in,
    input  logic [P_W-1:0]  c_in,
    output logic [OP_W-1:0] a_out,
    output logic [OP_W-1:0] b_out,
    output logic [P_W-1:0]  s_out,
    output logic [P_W-1:0]  c_out
);

    localparam logic ROW_IS_SIGN = (ROW == OP_W - 1);

    logic [P_W-1:0] pp;
    logic [P_W-1:0] sum_n;
    logic [P_W-1:0] maj_n;

    // Build the shifted partial-product row with sign-term inversion.
    always_comb begin
        pp = '0;
        for (int i = 0; i < OP_W; i++) begin
            pp[i + ROW] = (a_in[i] & b_in[ROW]) ^ ((i == OP_W - 1) != ROW_IS_SIGN);
        end
    end

    // One 3:2 full-adder row: sum bits and left-shifted carries.
    always_comb begin
        sum_n = s_in ^ c_in ^ pp;
        maj_n = (s_in & c_in) | (s_in & pp) | (c_in & pp);
    end

    // Stage register: partial result plus skewed operands.
    always_ff @(posedge clk) begin
        a_out <= a_in;
        b_out <= b_in;
        s_out <= sum_n;
        c_out <= {maj_n[P_W-2:0], 1'b0};
    end

endmodule

// File: rtl/bw_cpa_stage.sv
// Module: one registered slice of the final carry-propagate adder.
// Adds slice IDX (CH bits wide) of the sum and carry vectors with the
// incoming carry, writes those result bits, and registers everything
// for the next slice. Data registers carry no reset.
module bw_cpa_stage #(
    parameter int P_W = 16,
    parameter int CH  = 2,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic [P_W-1:0] s_in,
    input  logic [P_W-1:0] c_in,
    input  logic [P_W-1:0] r_in,
    input  logic           cy_in,
    output logic [P_W-1:0] s_out,
    output logic [P_W-1:0] c_out,
    output logic [P_W-1:0] r_out,
    output logic           cy_out
);

    localparam int LO = IDX * CH;

    logic [CH:0]    add_w;
    logic [P_W-1:0] r_n;

    // Add this slice with the carry from the slice below.
    always_comb begin
        add_w = {1'b0, s_in[LO +: CH]} + {1'b0, c_in[LO +: CH]} + {{CH{1'b0}}, cy_in};
        r_n = r_in;
        r_n[LO +: CH] = add_w[CH-1:0];
    end

    // Slice register.
    always_ff @(posedge clk) begin
        s_out  <= s_in;
        c_out  <= c_in;
        r_out  <= r_n;
        cy_out <= add_w[CH];
    end

endmodule

// File: rtl/bw_valid_pipe.sv
// Module: shift register that carries the valid flag beside the data path.
// Synchronous active-low reset clears every stage. Assumes DEPTH >= 1.
module bw_valid_pipe #(
    parameter int DEPTH = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    output logic vld_out
);

    logic [DEPTH-1:0] sr;

    // Shift the flag one stage per clock; reset clears all stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], vld_in};
    end

    assign vld_out = sr[DEPTH-1];

endmodule

// File: rtl/bw_mult.sv
// Module: fully pipelined signed multiplier with a carry-save array.
// An input register is followed by OP_W full-adder rows, each registered,
// then CPA_STAGES registered carry-propagate slices. This gives a latency
// of 1 + OP_W + CPA_STAGES cycles (17 at the defaults) and one result per
// clock. Assumes 2*OP_W is a multiple of CPA_STAGES.
module bw_mult #(
    parameter int OP_W       = bw_mult_pkg::OP_W_DEF,
    parameter int CPA_STAGES = bw_mult_pkg::CPA_STAGES_DEF,
    localparam int P_W       = 2 * OP_W,
    localparam int CH        = P_W / CPA_STAGES,
    localparam int LAT       = 1 + OP_W + CPA_STAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic            out_vld,
    output logic [P_W-1:0]  product
);

    logic [OP_W-1:0] a_pipe [0:OP_W];
    logic [OP_W-1:0] b_pipe [0:OP_W];
    logic [P_W-1:0]  s_pipe [0:OP_W];
    logic [P_W-1:0]  c_pipe [0:OP_W];

    logic [P_W-1:0]  cs_pipe [0:CPA_STAGES];
    logic [P_W-1:0]  cc_pipe [0:CPA_STAGES];
    logic [P_W-1:0]  cr_pipe [0:CPA_STAGES];
    logic            cy_pipe [0:CPA_STAGES];

    // Input register: capture the operands; no reset on data.
    always_ff @(posedge clk) begin
        a_pipe[0] <= op_a;
        b_pipe[0] <= op_b;
    end

    // The array starts from the correction constant with no carries.
    assign s_pipe[0] = bw_mult_pkg::corr_const(OP_W);
    assign c_pipe[0] = '0;

    // Carry-save array: one registered full-adder row per multiplier bit.
    for (genvar r = 0; r < OP_W; r++) begin : g_row
        bw_row_stage #(.OP_W(OP_W), .ROW(r)) u_row (
            .clk   (clk),
            .a_in  (a_pipe[r]),
            .b_in  (b_pipe[r]),
            .s_in  (s_pipe[r]),
            .c_in  (c_pipe[r]),
            .a_out (a_pipe[r+1]),
            .b_out (b_pipe[r+1]),
            .s_out (s_pipe[r+1]),
            .c_out (c_pipe[r+1])
        );
    end

    assign cs_pipe[0] = s_pipe[OP_W];
    assign cc_pipe[0] = c_pipe[OP_W];
    assign cr_pipe[0] = '0;
    assign cy_pipe[0] = 1'b0;

    // Final adder: CPA_STAGES registered slices of CH bits each.
    for (genvar k = 0; k < CPA_STAGES; k++) begin : g_cpa
        bw_cpa_stage #(.P_W(P_W), .CH(CH), .IDX(k)) u_cpa (
            .clk    (clk),
            .s_in   (cs_pipe[k]),
            .c_in   (cc_pipe[k]),
            .r_in   (cr_pipe[k]),
            .cy_in  (cy_pipe[k]),
            .s_out  (cs_pipe[k+1]),
            .c_out  (cc_pipe[k+1]),
            .r_out  (cr_pipe[k+1]),
            .cy_out (cy_pipe[k+1])
        );
    end

    // Valid flag travels beside the data for the full latency.
    bw_valid_pipe #(.DEPTH(LAT)) u_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (in_vld),
        .vld_out (out_vld)
    );

    assign product = cr_pipe[CPA_STAGES];

    // Tail values past the last stage are not needed (carry out is mod 2^P_W).
    logic unused_tail;
    assign unused_tail = ^{a_pipe[OP_W], b_pipe[OP_W], cs_pipe[CPA_STAGES],
                           cc_pipe[CPA_STAGES], cy_pipe[CPA_STAGES]};

endmodule

// File: rtl/bw_mult_chk.sv
// Module: assertion checker for bw_mult, bound to the top module.
// Keeps its own history of accepted requests and their signed products,
// then compares them with the outputs LAT cycles later.
module bw_mult_chk #(
    parameter int OP_W = 8,
    parameter int LAT  = 17,
    localparam int P_W = 2 * OP_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [OP_W-1:0] op_a,
    input logic [OP_W-1:0] op_b,
    input logic            out_vld,
    input logic [P_W-1:0]  product
);

    logic           h_vld  [0:LAT-1];
    logic [P_W-1:0] h_prod [0:LAT-1];
    logic signed [P_W-1:0] ref_prod;

    // Reference product computed directly from the signed operands.
    always_comb ref_prod = $signed(op_a) * $signed(op_b);

    // History shift register of requests and reference products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) h_vld[i] <= 1'b0;
        end else begin
            h_vld[0] <= in_vld;
            for (int i = 1; i < LAT; i++) h_vld[i] <= h_vld[i-1];
        end
        h_prod[0] <= ref_prod;
        for (int i = 1; i < LAT; i++) h_prod[i] <= h_prod[i-1];
    end

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && h_vld[LAT-1]) |-> (product == h_prod[LAT-1])); // R1

    AST_VALID_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        h_vld[LAT-1] |-> out_vld); // R2

    AST_NO_EXTRA_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !h_vld[LAT-1] |-> !out_vld); // R4

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && h_vld[LAT-2]) |=> out_vld); // R3

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_vld); // R5

    AST_PRODUCT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !$isunknown(product)); // R6

endmodule

bind bw_mult bw_mult_chk #(.OP_W(OP_W), .LAT(LAT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .out_vld (out_vld),
    .product (product)
);

// File: tb/tb_bw_mult.sv
// Directed bench for bw_mult: one task per scenario, each checking itself.
module tb_bw_mult;

    localparam int LAT  = 17;
    localparam int MAXN = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        out_vld;
    logic [15:0] product;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic       st_v [MAXN];
    logic [7:0] st_a [MAXN];
    logic [7:0] st_b [MAXN];

    bw_mult dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .product(product)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Play st_* for n cycles, then drain; check every output cycle.
    task automatic play(input int n, input string req);
        logic signed [15:0] e;
        for (int i = 0; i < n + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                chk(out_vld == st_v[i-LAT], {req, " valid R2/R4"}, {15'd0, out_vld}, {15'd0, st_v[i-LAT]});
                if (st_v[i-LAT]) begin
                    e = $signed(st_a[i-LAT]) * $signed(st_b[i-LAT]);
                    chk(product == e, {req, " product R1"}, product, e);
                end
            end else begin
                chk(out_vld == 1'b0, {req, " early valid R2"}, {15'd0, out_vld}, 16'd0);
            end
            if (i < n) begin
                in_vld = st_v[i]; op_a = st_a[i]; op_b = st_b[i];
            end else begin
                in_vld = 1'b0; op_a = 8'hxx ^ 8'h00; op_b = 8'h5a;
            end
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R5 reset state", {15'd0, out_vld}, 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_corners();
        logic [7:0] v [8] = '{8'h80, 8'h7f, 8'h00, 8'hff, 8'h01, 8'h81, 8'hfe, 8'h40};
        int n = 0;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                st_v[n] = 1'b1; st_a[n] = v[i]; st_b[n] = v[j]; n++;
            end
        play(n, "R6 corners");
    endtask

    task automatic t_corner_values();
        // R6 explicit values: -128*-128 and -128*127 back to back.
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            if (i == LAT)     chk(product == 16'h4000, "R6 -128*-128", product, 16'h4000);
            if (i == LAT + 1) chk(product == 16'hC080, "R6 -128*127", product, 16'hC080);
            in_vld = (i < 2);
            op_a = 8'h80;
            op_b = (i == 0) ? 8'h80 : 8'h7f;
        end
        in_vld = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    task automatic t_random_stream();
        for (int i = 0; i < 200; i++) begin
            st_v[i] = 1'b1; st_a[i] = 8'($urandom); st_b[i] = 8'($urandom);
        end
        play(200, "R3 stream");
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 150; i++) begin
            st_v[i] = ($urandom % 3) != 0; st_a[i] = 8'($urandom); st_b[i] = 8'($urandom);
        end
        play(150, "R4 bubbles");
    endtask

    task automatic t_reset_flush();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_vld = 1'b1; op_a = 8'($urandom); op_b = 8'($urandom);
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; in_vld = 1'b0;
        for (int i = 0; i < LAT + 3; i++) begin
            chk(out_vld == 1'b0, "R5 flushed", {15'd0, out_vld}, 16'd0);
            @(negedge clk);
        end
        // R2 after flush: a single new request lands exactly at LAT.
        st_v[0] = 1'b1; st_a[0] = 8'h85; st_b[0] = 8'h13;
        play(1, "R2 after reset");
    endtask

    initial begin
        t_reset_state();
        t_corner_values();
        t_corners();
        t_random_stream();
        t_bubbles();
        t_reset_flush();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule